// File: doc/BRIEF.md
# Dispatch Group Slot Checker

This block tracks how a superscalar front end fills a dispatch group of five slots. Each cycle it sees one candidate instruction, described by a unit class and a few flags. From these it produces a verdict without waiting for a clock edge. The verdict says the candidate can join the current group, must stall until a new group opens, or needs a no-op placed ahead of it so that a structural conflict is avoided.

The scheduler pulses `issue_i` when it commits the candidate, and the block then updates the group state. It pulses `advance_i` when a cycle passes with nothing dispatched, which uses up one empty slot. Address-overlap detection between loads and earlier stores happens in a neighbouring block. Its result arrives here as the single bit `ld_conflict_i`. The block reports how many stores the current group holds, so that the neighbour knows how many stores to compare against.

Top module: `dgc_group_checker`

## Requirements
- R1: The verdict encodes 2'b00 as no hazard, 2'b01 as stall and 2'b10 as insert no-op, and never takes the value 2'b11. Unit code 0 is a pseudo or debug instruction: its verdict is 2'b00, and issuing it leaves the slot count, the store count and the CTR flag unchanged.
- R2: While `rst_n` is low, the slot count, the store count and the CTR flag are all zero.
- R3: A candidate with `first_only_i` or `single_i` set gets a stall verdict whenever the slot count is not zero.
- R4: A candidate with `cracked_i` set gets a stall verdict when the slot count exceeds 2. Issuing a cracked op raises the slot count by two.
- R5: A condition-register unit candidate (unit code 6) gets a stall verdict when the slot count is 2 or more.
- R6: With four slots used, any candidate other than a branch (unit code 7) gets a stall verdict. A branch at that point gets no hazard.
- R7: Issuing a branch or a single-group candidate ends the group.
- R8: When a group ends, because the count reaches five or through R7, the slot count, the store count and the CTR flag all return to zero on the next cycle.
- R9: Once a candidate with `ctr_write_i` set has issued in the group, a candidate with `ctr_branch_i` set gets insert-no-op.
- R10: Each issued store raises the store count, which saturates at 4. `ld_conflict_i` gives insert-no-op only while the store count is non-zero. With the store count at zero it has no effect.
- R11: An advance pulse raises the slot count by one, and the fifth slot consumed ends the group. When issue and advance arrive in the same cycle, only the issue takes effect.
- R12: A placement stall takes priority over the CTR no-op, and the CTR no-op takes priority over the load-conflict no-op.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| unit_i | input | 3 | Unit class of the candidate (0 pseudo, 1-5 non-branch compute or memory, 6 condition register, 7 branch) |
| first_only_i | input | 1 | Candidate may only start a group |
| single_i | input | 1 | Candidate must sit alone in its group |
| cracked_i | input | 1 | Candidate splits into two ops |
| store_i | input | 1 | Candidate writes memory |
| ctr_write_i | input | 1 | Candidate writes the count register |
| ctr_branch_i | input | 1 | Candidate branches through the count register |
| ld_conflict_i | input | 1 | Neighbour reports the candidate load overlaps a tracked store |
| issue_i | input | 1 | Candidate is dispatched this cycle |
| advance_i | input | 1 | One empty slot passes this cycle |
| verdict_o | output | 2 | 00 no hazard, 01 stall, 10 insert no-op |
| slots_used_o | output | 3 | Slots used in the current group |
| store_cnt_o | output | 3 | Stores tracked in the current group |
| ctr_set_o | output | 1 | A count-register write has issued in the group |

## Verification
Directed sequences place each candidate kind at every slot boundary that matters: first-only at slot 1, cracked at slots 2 and 3, condition-register ops at slots 1 and 2, and non-branch versus branch at slot 4. These show that each limit falls exactly where it should. Combined cases stack a placement violation on top of a CTR conflict, and a CTR conflict on top of a load conflict, which separates the priority order from the individual rules. Seeded random streams with mixed issue and advance pulses then compare the verdict and the group state against a bench model every cycle. This exposes any group-end or counting error that the directed cases do not reach.

// File: rtl/dgc_pkg.sv
package dgc_pkg;
  typedef enum logic [2:0] {
    UNIT_PSEUDO = 3'd0,
    UNIT_FIX    = 3'd1,
    UNIT_LDST   = 3'd2,
    UNIT_FLT    = 3'd3,
    UNIT_VEC    = 3'd4,
    UNIT_PERM   = 3'd5,
    UNIT_CR     = 3'd6,
    UNIT_BR     = 3'd7
  } unit_e;

  typedef enum logic [1:0] {
    VERD_OK    = 2'b00,
    VERD_STALL = 2'b01,
    VERD_NOP   = 2'b10
  } verdict_e;
endpackage

// File: rtl/dgc_rules.sv
module dgc_rules
  import dgc_pkg::*;
#(
  parameter int NUM_SLOTS = 5,
  parameter int CR_SLOTS  = 2,
  parameter int CNT_W     = $clog2(NUM_SLOTS),
  parameter int SC_W      = 3
) (
  input  logic [2:0]       unit_i,
  input  logic             first_only_i,
  input  logic             single_i,
  input  logic             cracked_i,
  input  logic             ctr_branch_i,
  input  logic             ld_conflict_i,
  input  logic [CNT_W-1:0] slots_used_i,
  input  logic             ctr_set_i,
  input  logic [SC_W-1:0]  store_cnt_i,
  output logic [1:0]       verdict_o
);
  localparam logic [CNT_W-1:0] LAST_SLOT   = CNT_W'(NUM_SLOTS - 1);
  localparam logic [CNT_W-1:0] CRACK_LIMIT = CNT_W'(NUM_SLOTS - 3);
  localparam logic [CNT_W-1:0] CR_LIMIT    = CNT_W'(CR_SLOTS);

  unit_e    unit;
  logic     is_branch;
  logic     place_bad;
  verdict_e verd;

  always_comb begin
    unit      = unit_e'(unit_i);
    is_branch = (unit == UNIT_BR);
    place_bad = 1'b0;
    if ((slots_used_i != '0) && (first_only_i || single_i)) place_bad = 1'b1;
    if (cracked_i && (slots_used_i > CRACK_LIMIT))          place_bad = 1'b1;
    if (unit == UNIT_CR && slots_used_i >= CR_LIMIT)        place_bad = 1'b1;
    if (!is_branch && slots_used_i == LAST_SLOT)            place_bad = 1'b1;

    if (unit == UNIT_PSEUDO)                          verd = VERD_OK;
    else if (place_bad)                               verd = VERD_STALL;
    else if (ctr_set_i && ctr_branch_i)               verd = VERD_NOP;
    else if (ld_conflict_i && (store_cnt_i != '0))    verd = VERD_NOP;
    else                                              verd = VERD_OK;
    verdict_o = verd;
  end
endmodule

// File: rtl/dgc_state.sv
module dgc_state
  import dgc_pkg::*;
#(
  parameter int NUM_SLOTS   = 5,
  parameter int STORE_DEPTH = 4,
  parameter int CNT_W       = $clog2(NUM_SLOTS),
  parameter int SC_W        = $clog2(STORE_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       unit_i,
  input  logic             single_i,
  input  logic             cracked_i,
  input  logic             store_i,
  input  logic             ctr_write_i,
  input  logic             issue_i,
  input  logic             advance_i,
  output logic [CNT_W-1:0] slots_used_o,
  output logic [SC_W-1:0]  store_cnt_o,
  output logic             ctr_set_o
);
  localparam logic [CNT_W:0]   FULL      = (CNT_W+1)'(NUM_SLOTS);
  localparam logic [CNT_W-1:0] LAST_SLOT = CNT_W'(NUM_SLOTS - 1);
  localparam logic [SC_W-1:0]  SC_MAX    = SC_W'(STORE_DEPTH);

  logic [CNT_W-1:0] used_q, used_d;
  logic [SC_W-1:0]  sc_q, sc_d;
  logic             ctr_q, ctr_d;
  logic             upd_en;
  logic             grp_end;
  logic             real_issue;
  logic [CNT_W-1:0] base;
  logic [CNT_W:0]   sum;

  always_comb begin
    real_issue = issue_i && (unit_e'(unit_i) != UNIT_PSEUDO);
    upd_en     = real_issue || (advance_i && !issue_i);
    used_d     = used_q;
    sc_d       = sc_q;
    ctr_d      = ctr_q;
    grp_end    = 1'b0;
    base       = used_q;
    sum        = '0;
    if (real_issue) begin
      ctr_d = ctr_q | ctr_write_i;
      if (store_i && sc_q < SC_MAX) sc_d = sc_q + 1'b1;
      if (unit_e'(unit_i) == UNIT_BR || single_i) base = LAST_SLOT;
      sum = {1'b0, base} + (CNT_W+1)'(1) + (CNT_W+1)'(cracked_i);
    end else begin
      sum = {1'b0, used_q} + (CNT_W+1)'(1);
    end
    if (sum >= FULL) grp_end = 1'b1;
    else             used_d  = sum[CNT_W-1:0];
    if (grp_end) begin
      used_d = '0;
      sc_d   = '0;
      ctr_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      used_q <= '0;
      sc_q   <= '0;
      ctr_q  <= 1'b0;
    end else if (upd_en) begin
      used_q <= used_d;
      sc_q   <= sc_d;
      ctr_q  <= ctr_d;
    end
  end

  assign slots_used_o = used_q;
  assign store_cnt_o  = sc_q;
  assign ctr_set_o    = ctr_q;
endmodule

// File: rtl/dgc_group_checker.sv
module dgc_group_checker #(
  parameter int NUM_SLOTS   = 5,
  parameter int STORE_DEPTH = 4,
  parameter int CR_SLOTS    = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] unit_i,
  input  logic       first_only_i,
  input  logic       single_i,
  input  logic       cracked_i,
  input  logic       store_i,
  input  logic       ctr_write_i,
  input  logic       ctr_branch_i,
  input  logic       ld_conflict_i,
  input  logic       issue_i,
  input  logic       advance_i,
  output logic [1:0] verdict_o,
  output logic [2:0] slots_used_o,
  output logic [2:0] store_cnt_o,
  output logic       ctr_set_o
);
  localparam int CNT_W = $clog2(NUM_SLOTS);
  localparam int SC_W  = $clog2(STORE_DEPTH + 1);

  logic [CNT_W-1:0] used;
  logic [SC_W-1:0]  sc;
  logic             ctr;

  dgc_state #(
    .NUM_SLOTS(NUM_SLOTS), .STORE_DEPTH(STORE_DEPTH),
    .CNT_W(CNT_W), .SC_W(SC_W)
  ) u_state (
    .clk(clk), .rst_n(rst_n), .unit_i(unit_i), .single_i(single_i),
    .cracked_i(cracked_i), .store_i(store_i), .ctr_write_i(ctr_write_i),
    .issue_i(issue_i), .advance_i(advance_i),
    .slots_used_o(used), .store_cnt_o(sc), .ctr_set_o(ctr)
  );

  dgc_rules #(
    .NUM_SLOTS(NUM_SLOTS), .CR_SLOTS(CR_SLOTS), .CNT_W(CNT_W), .SC_W(SC_W)
  ) u_rules (
    .unit_i(unit_i), .first_only_i(first_only_i), .single_i(single_i),
    .cracked_i(cracked_i), .ctr_branch_i(ctr_branch_i),
    .ld_conflict_i(ld_conflict_i), .slots_used_i(used), .ctr_set_i(ctr),
    .store_cnt_i(sc), .verdict_o(verdict_o)
  );

  assign slots_used_o = 3'(used);
  assign store_cnt_o  = 3'(sc);
  assign ctr_set_o    = ctr;
endmodule

// File: rtl/dgc_group_checker_chk.sv
module dgc_group_checker_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] unit_i,
  input logic       first_only_i,
  input logic       single_i,
  input logic       cracked_i,
  input logic       issue_i,
  input logic       advance_i,
  input logic [1:0] verdict_o,
  input logic [2:0] slots_used_o,
  input logic [2:0] store_cnt_o,
  input logic       ctr_set_o
);
  // R1
  verdict_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    verdict_o != 2'b11);

  // R1
  pseudo_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_i && unit_i == 3'd0) |=> ($stable(slots_used_o) && $stable(store_cnt_o) && $stable(ctr_set_o)));

  // R3
  first_late_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (unit_i != 3'd0 && (first_only_i || single_i) && slots_used_o != 3'd0) |-> verdict_o == 2'b01);

  // R4
  cracked_two_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_i && cracked_i && !single_i && unit_i != 3'd0 && unit_i != 3'd7 && slots_used_o <= 3'd2)
      |=> slots_used_o == $past(slots_used_o) + 3'd2);

  // R7
  branch_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_i && unit_i == 3'd7) |=> (slots_used_o == 3'd0 && store_cnt_o == 3'd0 && !ctr_set_o));

  // R10
  store_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    store_cnt_o <= 3'd4);

  // R11
  slot_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slots_used_o <= 3'd4);

  // R11
  advance_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (advance_i && !issue_i && slots_used_o < 3'd4) |=> slots_used_o == $past(slots_used_o) + 3'd1);
endmodule

bind dgc_group_checker dgc_group_checker_chk u_chk (
  .clk(clk), .rst_n(rst_n), .unit_i(unit_i), .first_only_i(first_only_i),
  .single_i(single_i), .cracked_i(cracked_i), .issue_i(issue_i),
  .advance_i(advance_i), .verdict_o(verdict_o), .slots_used_o(slots_used_o),
  .store_cnt_o(store_cnt_o), .ctr_set_o(ctr_set_o)
);

// File: tb/tb_dgc_group_checker.sv
module tb_dgc_group_checker;
  logic       clk;
  logic       rst_n;
  logic [2:0] unit_i;
  logic       first_only_i, single_i, cracked_i, store_i;
  logic       ctr_write_i, ctr_branch_i, ld_conflict_i, issue_i, advance_i;
  logic [1:0] verdict_o;
  logic [2:0] slots_used_o, store_cnt_o;
  logic       ctr_set_o;

  int checks = 0;
  int fails  = 0;
  int m_used = 0;
  int m_sc   = 0;
  bit m_ctr  = 0;
  bit done   = 0;

  dgc_group_checker dut (.*);

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_verdict();
    bit bad;
    if (unit_i == 3'd0) return 0;
    bad = (m_used != 0 && (first_only_i || single_i)) || (cracked_i && m_used > 2)
       || (unit_i == 3'd6 && m_used >= 2) || (unit_i != 3'd7 && m_used == 4);
    if (bad) return 1;
    if (m_ctr && ctr_branch_i) return 2;
    if (ld_conflict_i && m_sc != 0) return 2;
    return 0;
  endfunction

  task automatic model_next();
    int s;
    bit endg;
    endg = 0;
    if (issue_i && unit_i != 3'd0) begin
      if (ctr_write_i) m_ctr = 1;
      if (store_i && m_sc < 4) m_sc++;
      s = (unit_i == 3'd7 || single_i) ? 4 : m_used;
      s = s + 1 + int'(cracked_i);
      if (s >= 5) endg = 1; else m_used = s;
    end else if (advance_i && !issue_i) begin
      if (m_used + 1 >= 5) endg = 1; else m_used++;
    end
    if (endg) begin m_used = 0; m_sc = 0; m_ctr = 0; end
  endtask

  task automatic step(input string tag, input logic [2:0] u, input bit fo, input bit sg,
                      input bit cr, input bit st, input bit cw, input bit cb,
                      input bit lc, input bit iss, input bit adv);
    @(negedge clk);
    unit_i = u; first_only_i = fo; single_i = sg; cracked_i = cr; store_i = st;
    ctr_write_i = cw; ctr_branch_i = cb; ld_conflict_i = lc; issue_i = iss; advance_i = adv;
    #1;
    chk(tag, int'(verdict_o), exp_verdict());
    chk(tag, int'(slots_used_o), m_used);
    chk(tag, int'(store_cnt_o), m_sc);
    chk(tag, int'(ctr_set_o), int'(m_ctr));
    model_next();
  endtask

  task automatic idle();
    step("R11", 3'd0, 0,0,0,0,0,0,0, 0, 0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; issue_i = 0; advance_i = 0;
    #1;
    m_used = 0; m_sc = 0; m_ctr = 0;
    // R2
    chk("R2", int'(slots_used_o), 0);
    chk("R2", int'(store_cnt_o), 0);
    chk("R2", int'(ctr_set_o), 0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 17;
    void'($urandom(seed));
    unit_i = 0; first_only_i = 0; single_i = 0; cracked_i = 0; store_i = 0;
    ctr_write_i = 0; ctr_branch_i = 0; ld_conflict_i = 0; issue_i = 0; advance_i = 0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    do_reset();

    // R3: first-only after one slot used
    step("R3", 3'd1, 0,0,0,0,0,0,0, 1, 0);
    step("R3", 3'd1, 1,0,0,0,0,0,0, 0, 0);
    step("R3", 3'd1, 0,1,0,0,0,0,0, 0, 0);
    // R5: CR at slot 1 fine, slot 2 stall
    step("R5", 3'd6, 0,0,0,0,0,0,0, 1, 0);
    step("R5", 3'd6, 0,0,0,0,0,0,0, 0, 0);
    // R4: cracked at 2 ok, issue to 4
    step("R4", 3'd2, 0,0,1,0,0,0,0, 0, 0);
    do_reset();
    step("R4", 3'd1, 0,0,0,0,0,0,0, 0, 1);
    step("R4", 3'd1, 0,0,0,0,0,0,0, 0, 1);
    step("R4", 3'd2, 0,0,1,0,0,0,0, 1, 0);
    // R6: at four, non-branch stalls, branch ok and closes (R7)
    step("R6", 3'd3, 0,0,0,0,0,0,0, 0, 0);
    step("R6", 3'd7, 0,0,0,0,0,0,0, 0, 0);
    step("R7", 3'd7, 0,0,0,0,0,0,0, 1, 0);
    step("R7", 3'd1, 0,0,0,0,0,0,0, 0, 0);
    // R4: cracked at 3 stalls
    step("R4", 3'd1, 0,0,0,0,0,0,0, 0, 1);
    step("R4", 3'd1, 0,0,0,0,0,0,0, 0, 1);
    step("R4", 3'd1, 0,0,0,0,0,0,0, 0, 1);
    step("R4", 3'd1, 0,0,1,0,0,0,0, 0, 0);
    step("R11", 3'd1, 0,0,0,0,0,0,0, 0, 1);
    step("R11", 3'd1, 0,0,0,0,0,0,0, 0, 1);
    // R9 and R12
    step("R9", 3'd1, 0,0,0,0,1,0,0, 1, 0);
    step("R9", 3'd7, 0,0,0,0,0,1,0, 0, 0);
    step("R12", 3'd6, 0,0,0,0,0,1,0, 1, 0);
    step("R12", 3'd6, 0,0,0,0,0,1,1, 0, 0);
    do_reset();
    // R10: conflict ignored without stores
    step("R10", 3'd2, 0,0,0,0,0,0,1, 0, 0);
    step("R10", 3'd2, 0,0,0,1,0,0,0, 1, 0);
    step("R10", 3'd2, 0,0,0,0,0,0,1, 0, 0);
    step("R12", 3'd7, 0,0,0,0,0,0,1, 0, 0);
    // R1: pseudo issue no effect
    step("R1", 3'd0, 1,1,1,1,1,1,1, 1, 0);
    step("R1", 3'd0, 0,0,0,0,0,0,0, 0, 0);
    // R8: fill with stores and ctr, then advance ends group
    step("R8", 3'd2, 0,0,0,1,1,0,0, 1, 0);
    step("R8", 3'd2, 0,0,0,1,0,0,0, 1, 0);
    step("R8", 3'd2, 0,0,0,1,0,0,0, 1, 0);
    step("R8", 3'd1, 0,0,0,0,0,0,0, 0, 1);
    step("R8", 3'd1, 0,0,0,0,0,0,0, 0, 0);
    // R11: issue and advance together count once
    step("R11", 3'd1, 0,0,0,0,0,0,0, 1, 1);
    step("R11", 3'd1, 0,0,0,0,0,0,0, 0, 0);
    // R7: single-group closes
    do_reset();
    step("R7", 3'd1, 0,1,0,1,1,0,0, 1, 0);
    idle();

    for (int i = 0; i < 3000; i++) begin
      logic [2:0] u;
      u = 3'($urandom_range(0, 7));
      step("R12", u, ($urandom_range(0, 9) == 0), ($urandom_range(0, 11) == 0),
           ($urandom_range(0, 5) == 0), ($urandom_range(0, 2) == 0),
           ($urandom_range(0, 4) == 0), ($urandom_range(0, 2) == 0),
           ($urandom_range(0, 2) == 0), ($urandom_range(0, 9) < 6),
           ($urandom_range(0, 9) < 3));
      if (i % 700 == 699) do_reset();
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule